// File: doc/BRIEF.md
# Programmed Operator Trap Sequencer

This block performs the entry into a software-emulated instruction on a 24-bit word machine. Bit positions are numbered from the most significant end. Bit 0 is `instr[23]` and bit 23 is `instr[0]`. A decoder presents an instruction word together with a `start` strobe. If the operator flag is set, the sequencer runs a fixed three-cycle sequence:

1. It optionally switches the processor to monitor mode.
2. It writes a linkage word to memory address zero and clears the overflow indicator in the same cycle.
3. It loads the program counter with the operator's vector address.

The linkage word holds the address of the trapping instruction, the overflow state at the moment of the trap, and a preset indirect flag. With that flag, the service routine can reach the caller's operand by indirecting through word zero. A user-mode instruction with the top bit set is a system call. It first moves the machine to monitor mode, then vectors into monitor space. Other operators vector within the caller's current space. The `mem_user` output tells the memory side which map applies. The service routine and the return from it belong to other logic.

Top module: `xop_trap_seq`

## Requirements
- R1: `start` is sampled only while `busy` is low. If bit 2 (`instr[21]`) is 0, the sample starts nothing: `busy`, `mem_we`, `pc_we` and `mode_we` stay low.
- R2: The linkage word is written to address 0. Its fields are:
  - `[13:0]`: the `pc` input captured at `start`.
  - `[14]`: bit 9, always 1.
  - `[23]`: bit 0, the captured `ovf_in`.
  - All other bits: 0.
- R3: `ovf_clr` pulses for exactly the one cycle in which `mem_we` is high.
- R4: The operator number is bits 3–8, `instr[20:15]`. `pc_next` equals 64 (octal 100) plus that number, so it lies in 64..127.
- R5: Mode encoding: 00 normal, 01 monitor, 10 user, 11 reserved (treated as normal). In user mode (10), an operator with `instr[23]`=1 is a system call. It raises `mode_we` with `mode_next`=01 in the first busy cycle, and it drives `mem_user`=0 for the write and the vector.
- R6: In user mode, an operator with `instr[23]`=0 does not raise `mode_we`. It drives `mem_user`=1 for the write and the vector.
- R7: Outside user mode, `instr[23]` is ignored. There is no mode change and `mem_user`=0.
- R8: `busy` stays high for exactly three cycles after the accepting edge, with one event per cycle in this order:
  1. Cycle 1: the mode step.
  2. Cycle 2: the linkage write.
  3. Cycle 3: the PC load (`pc_we`).
- R9: `start` while `busy` is high is ignored. The linkage data and vector of the running sequence do not change, and no extra sequence follows.
- R10: After reset, `busy`, `mem_we`, `pc_we`, `mode_we` and `ovf_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Decoded instruction presented |
| instr | input | 24 | Instruction word |
| pc | input | 14 | Address of that instruction |
| ovf_in | input | 1 | Current overflow indicator |
| mode_in | input | 2 | Current processor mode |
| busy | output | 1 | Sequence in progress |
| mode_we | output | 1 | Mode update strobe |
| mode_next | output | 2 | New mode value |
| mem_we | output | 1 | Linkage write strobe |
| mem_addr | output | 14 | Linkage write address |
| mem_wdata | output | 24 | Linkage word |
| mem_user | output | 1 | Write and vector use the user map |
| ovf_clr | output | 1 | Clear the overflow indicator |
| pc_we | output | 1 | PC load strobe |
| pc_next | output | 14 | Vector address |

## Verification
On every cycle, the embedded properties watch four things:
- The ordering of the strobes (mode step before write, write before PC load, `busy` dropping only after the load).
- The pairing of `ovf_clr` with the write.
- The vector range.
- That a system call never targets the user map and linkage data holds still while busy.

Only the bench scenarios can show that the exact linkage word, vector number and map choice match the instruction and mode actually presented. The same goes for showing that non-operator words and mid-sequence strobes leave the outputs untouched, and that the reserved mode acts as normal.

// File: rtl/xop_pkg.sv
package xop_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_MONITOR = 2'b01,
        MODE_USER    = 2'b10,
        MODE_RSVD    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_MODE = 2'b01,
        SEQ_LINK = 2'b10,
        SEQ_VEC  = 2'b11
    } seq_e;
endpackage

// File: rtl/xop_decode.sv
module xop_decode
    import xop_pkg::*;
#(
    parameter int NUM_W = 6
) (
    input  logic [2:0]       tag,
    input  logic [NUM_W-1:0] num_field,
    input  logic [1:0]       mode_in,
    output logic             is_pop,
    output logic             is_sys,
    output logic             is_user,
    output logic [NUM_W-1:0] op_num
);
    // tag[2] is the top bit of the word, tag[0] the operator flag
    logic in_user;

    always_comb begin
        in_user = (mode_e'(mode_in) == MODE_USER);
        is_pop  = tag[0];
        is_sys  = tag[0] && tag[2] && in_user;
        is_user = tag[0] && !tag[2] && in_user;
        op_num  = num_field;
    end
endmodule

// File: rtl/xop_link_build.sv
module xop_link_build #(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              ovf,
    output logic [WORD_W-1:0] link
);
    localparam int IND_POS = WORD_W - 10;
    localparam int OVF_POS = WORD_W - 1;

    always_comb begin
        link            = '0;
        link[ADDR_W-1:0] = pc;
        link[IND_POS]   = 1'b1;
        link[OVF_POS]   = ovf;
    end
endmodule

// File: rtl/xop_vector.sv
module xop_vector #(
    parameter int ADDR_W   = 14,
    parameter int NUM_W    = 6,
    parameter int VEC_BASE = 64
) (
    input  logic [NUM_W-1:0]  op_num,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);

    always_comb begin
        vec_addr = BASE_A + ADDR_W'(op_num);
    end
endmodule

// File: rtl/xop_trap_seq.sv
module xop_trap_seq
    import xop_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int ADDR_W    = 14,
    parameter int NUM_W     = 6,
    parameter int VEC_BASE  = 64,
    parameter int LINK_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic              ovf_in,
    input  logic [1:0]        mode_in,
    output logic              busy,
    output logic              mode_we,
    output logic [1:0]        mode_next,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_user,
    output logic              ovf_clr,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_next
);
    localparam int NUM_HI = WORD_W - 4;
    localparam int LOW_HI = NUM_HI - NUM_W;

    typedef struct packed {
        seq_e              st;
        logic [NUM_W-1:0]  num;
        logic [WORD_W-1:0] link;
        logic              sys;
        logic              usr;
    } regs_t;

    regs_t r_d, r_q;

    logic             dec_pop, dec_sys, dec_user;
    logic [NUM_W-1:0] dec_num;
    logic [WORD_W-1:0] link_w;
    logic [ADDR_W-1:0] vec_w;
    logic             unused_low;

    assign unused_low = ^instr[LOW_HI:0];

    xop_decode #(.NUM_W(NUM_W)) dec_i (
        .tag      (instr[WORD_W-1 -: 3]),
        .num_field(instr[NUM_HI -: NUM_W]),
        .mode_in  (mode_in),
        .is_pop   (dec_pop),
        .is_sys   (dec_sys),
        .is_user  (dec_user),
        .op_num   (dec_num)
    );

    xop_link_build #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) link_i (
        .pc  (pc),
        .ovf (ovf_in),
        .link(link_w)
    );

    xop_vector #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .VEC_BASE(VEC_BASE)) vec_i (
        .op_num  (r_q.num),
        .vec_addr(vec_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start && dec_pop) begin
                    r_d.st   = SEQ_MODE;
                    r_d.num  = dec_num;
                    r_d.link = link_w;
                    r_d.sys  = dec_sys;
                    r_d.usr  = dec_user;
                end
            end
            SEQ_MODE: r_d.st = SEQ_LINK;
            SEQ_LINK: r_d.st = SEQ_VEC;
            SEQ_VEC:  r_d.st = SEQ_IDLE;
            default:  r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: SEQ_IDLE, num: '0, link: '0, sys: 1'b0, usr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != SEQ_IDLE);
        mode_we   = (r_q.st == SEQ_MODE) && r_q.sys;
        mode_next = MODE_MONITOR;
        mem_we    = (r_q.st == SEQ_LINK);
        ovf_clr   = (r_q.st == SEQ_LINK);
        mem_addr  = ADDR_W'(LINK_ADDR);
        mem_wdata = r_q.link;
        mem_user  = r_q.usr;
        pc_we     = (r_q.st == SEQ_VEC);
        pc_next   = vec_w;
    end

    // R8
    mode_then_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mem_we);
    // R8
    link_then_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> pc_we);
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pc_we));
    // R3
    ovf_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |-> (mem_we && !pc_we && !mode_we));
    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (int'(pc_next) >= VEC_BASE && int'(pc_next) < VEC_BASE + (1 << NUM_W)));
    // R5
    sys_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |-> !mem_user);
    // R9
    hold_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pc_we) |=> $stable(mem_wdata));
    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && instr[WORD_W-3]) |=> busy);
endmodule

// File: tb/xop_trap_seq_tb_top.sv
module xop_trap_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        sys;
        logic        usr;
        logic [23:0] link;
        logic [13:0] vec;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] instr = '0;
    logic [13:0] pc = '0;
    logic        ovf_in = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic        busy, mode_we, mem_we, mem_user, ovf_clr, pc_we;
    logic [1:0]  mode_next;
    logic [13:0] mem_addr, pc_next;
    logic [23:0] mem_wdata;

    int   errors = 0;
    int   checks = 0;
    int   n_vec = 0;
    int   n_exp = 0;
    int   phase = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xop_trap_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
        .ovf_in(ovf_in), .mode_in(mode_in), .busy(busy), .mode_we(mode_we),
        .mode_next(mode_next), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_user(mem_user), .ovf_clr(ovf_clr),
        .pc_we(pc_we), .pc_next(pc_next)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_instr(input logic b0, input logic b2, input logic [5:0] num,
                                             input logic [14:0] low);
        return {b0, 1'b0, b2, num, low};
    endfunction

    // driver: presents one word, pushes expectation when an operator is accepted
    task automatic drive(input logic [23:0] w, input logic [13:0] p, input logic ov, input logic [1:0] md);
        exp_t e;
        @(negedge clk);
        instr = w; pc = p; ovf_in = ov; mode_in = md; start = 1'b1;
        if (w[21]) begin
            e.sys  = (md == 2'b10) && w[23];
            e.usr  = (md == 2'b10) && !w[23];
            e.link = {ov, 8'h00, 1'b1, p};
            e.vec  = 14'd64 + {8'd0, w[20:15]};
            q.push_back(e);
            n_exp++;
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: compares each busy cycle against the queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) begin
                if (phase != 0 && phase != 3) chk("R8 busy length", phase, 3);
                phase = 0;
                if (mem_we || pc_we || mode_we || ovf_clr) chk("R1 strobe while idle", 1, 0);
            end else if (q.size() == 0) begin
                chk("R1 unexpected sequence", busy, 0);
            end else begin
                phase++;
                case (phase)
                    1: begin
                        chk("R8 cycle1 no write", {mem_we, pc_we}, 0);
                        chk("R5/R6/R7 mode_we", mode_we, q[0].sys);
                        if (q[0].sys) chk("R5 mode_next", mode_next, 2'b01);
                    end
                    2: begin
                        chk("R8 cycle2 write", {mode_we, mem_we, pc_we}, 3'b010);
                        chk("R2 addr", mem_addr, 0);
                        chk("R2 link word", mem_wdata, q[0].link);
                        chk("R3 ovf_clr", ovf_clr, 1);
                        chk("R5/R6/R7 map", mem_user, q[0].usr);
                    end
                    3: begin
                        chk("R8 cycle3 pc", {mode_we, mem_we, pc_we}, 3'b001);
                        chk("R4 vector", pc_next, q[0].vec);
                        chk("R5/R6/R7 map at vector", mem_user, q[0].usr);
                        chk("R3 ovf_clr low", ovf_clr, 0);
                        n_vec++;
                        void'(q.pop_front());
                    end
                    default: chk("R8 busy too long", phase, 3);
                endcase
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        chk("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk("R10 reset outputs", {busy, mem_we, pc_we, mode_we, ovf_clr}, 0);

        // R2 R4 R7 normal mode, top bit ignored
        drive(mk_instr(1'b1, 1'b1, 6'o05, 15'h1234), 14'o12345, 1'b1, 2'b00);
        repeat (4) @(negedge clk);
        // R6 ordinary user operator
        drive(mk_instr(1'b0, 1'b1, 6'o77, 15'h7fff), 14'o37777, 1'b0, 2'b10);
        repeat (4) @(negedge clk);
        // R5 system call from user mode
        drive(mk_instr(1'b1, 1'b1, 6'o00, 15'h0000), 14'o00000, 1'b1, 2'b10);
        repeat (4) @(negedge clk);
        // R7 monitor mode and reserved mode ignore the top bit
        drive(mk_instr(1'b1, 1'b1, 6'o40, 15'h0aaa), 14'o20001, 1'b0, 2'b01);
        repeat (4) @(negedge clk);
        drive(mk_instr(1'b1, 1'b1, 6'o17, 15'h5555), 14'o07070, 1'b1, 2'b11);
        repeat (4) @(negedge clk);

        // R1 non-operator words start nothing
        drive(mk_instr(1'b1, 1'b0, 6'o33, 15'h7fff), 14'o11111, 1'b1, 2'b10);
        @(negedge clk);
        chk("R1 no busy for plain word", busy, 0);
        repeat (3) @(negedge clk);
        chk("R1 vector count", n_vec, n_exp);

        // R9 start during busy ignored
        drive(mk_instr(1'b0, 1'b1, 6'o21, 15'h0001), 14'o00100, 1'b0, 2'b00);
        instr = mk_instr(1'b1, 1'b1, 6'o62, 15'h0002);
        pc = 14'o33333; ovf_in = 1'b1; mode_in = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 idle after sequence", busy, 0);
        chk("R9 no extra sequence", n_vec, n_exp);

        // R8 back-to-back accepted right after busy drops
        drive(mk_instr(1'b0, 1'b1, 6'o01, 15'h0000), 14'o00002, 1'b1, 2'b10);
        repeat (2) @(negedge clk);
        drive(mk_instr(1'b1, 1'b1, 6'o76, 15'h0000), 14'o17776, 1'b0, 2'b10);
        repeat (5) @(negedge clk);
        chk("R8 all sequences done", n_vec, n_exp);
        chk("R8 queue empty", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule